// File: doc/BRIEF.md
# Load/Store Address Unit

This block turns one memory-format instruction word, the value of its base register and the value of its offset register into the effective memory address. It also produces the base-register update for instructions that modify their base. It decodes the indexing control bits and builds the offset. The offset is either a 12-bit unsigned immediate or the offset register passed through a barrel shifter. The offset is then added to or subtracted from the base. Three indexing modes are supported: plain offset, pre-indexed with base update, and post-indexed with base update.

Results are captured on the clock edge after an accepted request. They are announced by a single-cycle valid pulse. A write-back enable, the index of the register to write and the value to write come with the address.

The register file and the data memory stay outside the block. For loads, the caller presents the word read from memory on `ld_word`. The block returns that word for word loads. For byte loads it returns the byte selected by the low address bits, zero-extended. A byte-order input, registered with the request, chooses between little-endian and big-endian byte numbering.

Top module: `ls_agu`

## Requirements
- R1: An instruction is in memory format only when bits [27:26] equal 2'b01. Any other value reports `illegal` and suppresses write-back. The control bits are bit 25 = register offset (1) / immediate (0), bit 24 = pre, bit 23 = up, bit 22 = byte, bit 21 = base update, bit 20 = load. The base register index sits in bits [19:16].
- R2: With bit 25 = 0 the offset is bits [11:0], zero-extended to the data width.
- R3: With bit 25 = 1 the offset is the offset register value shifted by bits [11:7]. The shift kind is taken from bits [6:5]: 00 shift left, 01 logical right, 10 arithmetic right, 11 rotate right. A shift amount of 0 passes the value unchanged.
- R4: With bit 23 = 1 the offset is added to the base; with bit 23 = 0 it is subtracted.
- R5: Pre = 1, update = 0: the address is base ± offset and `wb_en` stays low. `wb_val` still shows base ± offset.
- R6: Pre = 1, update = 1: the address is base ± offset, and `wb_en` is high with `wb_val` equal to that same address and `wb_idx` equal to bits [19:16].
- R7: Pre = 0, update = 0: the address is the base unchanged, `wb_en` is high and `wb_val` is base ± offset.
- R8: Pre = 0, update = 1 is not supported. It reports `illegal` with `wb_en` low, and the address is the unchanged base.
- R9: For a load, `ld_result` is `ld_word` for a word access. For a byte access it is the byte selected by address bits [1:0], zero-extended, with byte k at bits [8k+7:8k] in little-endian order. For a store, `ld_result` is zero.
- R10: When the registered byte-order input is 1, byte k is taken from bits [31-8k:24-8k]. Byte 1 of 0x23456789 is then 0x45, and 0x67 in little-endian order.
- R11: Outputs are updated on the clock edge that accepts `in_valid`. `out_valid` is high for exactly the cycles that follow an accepting edge. `wb_en` and `illegal` are only ever high together with `out_valid`. Address, write-back value, index and flags hold while no request arrives.
- R12: Asserting `rst_n` low clears every output to zero at once. The block leaves reset on the second clock edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| instr | input | 32 | Memory-format instruction word |
| base_val | input | 32 | Value of the base register |
| ofs_val | input | 32 | Value of the offset register |
| big_end | input | 1 | Byte order for byte loads (1 = most significant byte first) |
| ld_word | input | 32 | Word read from memory at the aligned address |
| out_valid | output | 1 | One-cycle result strobe |
| mem_addr | output | 32 | Effective memory address |
| wb_en | output | 1 | Base register update enable |
| wb_idx | output | 4 | Index of the base register to update |
| wb_val | output | 32 | Updated base value |
| is_load | output | 1 | Access is a load |
| is_byte | output | 1 | Access is a byte access |
| illegal | output | 1 | Unsupported or non-memory encoding |
| ld_result | output | 32 | Load data after byte selection and zero extension |

## Verification
Address, write-back enable, write-back value, index and flags are due one clock edge after the edge that accepts a request. The bench drives each request on a falling edge and compares all of them on the next falling edge. `ld_result` depends on the registered address and flags and on the live `ld_word`, so it is checked in that same window while `ld_word` is held. The idle checks sample one and two cycles after the request to see the strobe fall and the results hold. The reset checks sample a nanosecond after `rst_n` falls, since that clear does not wait for a clock.

// File: rtl/ls_agu_pkg.sv
package ls_agu_pkg;

  localparam int INSTR_W = 32;
  localparam int IMM_W   = 12;
  localparam int SHAMT_W = 5;
  localparam int REGIX_W = 4;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_kind_e;

  typedef enum logic [1:0] {
    MODE_OFFSET = 2'b00,
    MODE_PRE    = 2'b01,
    MODE_POST   = 2'b10,
    MODE_BAD    = 2'b11
  } idx_mode_e;

endpackage

// File: rtl/ls_rst_sync.sv
module ls_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_q_n <= stage_q;
    end
  end

endmodule

// File: rtl/ls_field_decode.sv
module ls_field_decode
  import ls_agu_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output logic               reg_ofs,
  output logic               up,
  output logic               byte_acc,
  output logic               load,
  output logic [REGIX_W-1:0] rn,
  output logic [IMM_W-1:0]   imm,
  output logic [SHAMT_W-1:0] shamt,
  output shift_kind_e        sh,
  output idx_mode_e          mode,
  output logic               bad
);

  localparam int FMT_HI = 27;
  localparam int FMT_LO = 26;
  localparam logic [1:0] FMT_MEM = 2'b01;

  logic pre;
  logic wback;
  logic mem_fmt;
  logic unused_bits;

  always_comb begin
    mem_fmt  = (instr[FMT_HI:FMT_LO] == FMT_MEM);
    reg_ofs  = instr[25];
    pre      = instr[24];
    up       = instr[23];
    byte_acc = instr[22];
    wback    = instr[21];
    load     = instr[20];
    rn       = instr[19:16];
    imm      = instr[IMM_W-1:0];
    shamt    = instr[11:7];
    sh       = shift_kind_e'(instr[6:5]);

    unique case ({pre, wback})
      2'b10:   mode = MODE_OFFSET;
      2'b11:   mode = MODE_PRE;
      2'b00:   mode = MODE_POST;
      default: mode = MODE_BAD;
    endcase

    bad = !mem_fmt || (mode == MODE_BAD);
  end

  assign unused_bits = ^{instr[31:28], instr[15:12]};

endmodule

// File: rtl/ls_offset_gen.sv
module ls_offset_gen
  import ls_agu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic               reg_ofs,
  input  logic [IMM_W-1:0]   imm,
  input  logic [SHAMT_W-1:0] shamt,
  input  shift_kind_e        sh,
  input  logic [DW-1:0]      ofs_val,
  output logic [DW-1:0]      ofs
);

  localparam int PAD_W = DW - IMM_W;

  logic [DW-1:0]   shifted;
  logic [2*DW-1:0] rot_dbl;

  always_comb begin
    rot_dbl = {ofs_val, ofs_val} >> shamt;
    unique case (sh)
      SH_LSL:  shifted = ofs_val << shamt;
      SH_LSR:  shifted = ofs_val >> shamt;
      SH_ASR:  shifted = $unsigned($signed(ofs_val) >>> shamt);
      default: shifted = rot_dbl[DW-1:0];
    endcase

    if (reg_ofs) begin
      ofs = shifted;
    end else begin
      ofs = {{PAD_W{1'b0}}, imm};
    end
  end

endmodule

// File: rtl/ls_lane_pick.sv
module ls_lane_pick #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]        word,
  input  logic [$clog2(DW/8)-1:0] lane,
  input  logic                 big_end,
  input  logic                 byte_acc,
  input  logic                 load,
  output logic [DW-1:0]        result
);

  localparam int LANES = DW / 8;
  localparam int PAD_W = DW - 8;

  logic [7:0] lane_le [LANES];
  logic [7:0] lane_be [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_le[g] = word[8*g +: 8];
    assign lane_be[g] = word[DW-8-8*g +: 8];
  end

  always_comb begin
    if (!load) begin
      result = '0;
    end else if (byte_acc) begin
      result = {{PAD_W{1'b0}}, (big_end ? lane_be[lane] : lane_le[lane])};
    end else begin
      result = word;
    end
  end

endmodule

// File: rtl/ls_agu.sv
module ls_agu
  import ls_agu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DW-1:0]      base_val,
  input  logic [DW-1:0]      ofs_val,
  input  logic               big_end,
  input  logic [DW-1:0]      ld_word,
  output logic               out_valid,
  output logic [DW-1:0]      mem_addr,
  output logic               wb_en,
  output logic [REGIX_W-1:0] wb_idx,
  output logic [DW-1:0]      wb_val,
  output logic               is_load,
  output logic               is_byte,
  output logic               illegal,
  output logic [DW-1:0]      ld_result
);

  localparam int LANE_W = $clog2(DW / 8);

  logic rst_q_n;

  logic               d_reg_ofs;
  logic               d_up;
  logic               d_byte;
  logic               d_load;
  logic [REGIX_W-1:0] d_rn;
  logic [IMM_W-1:0]   d_imm;
  logic [SHAMT_W-1:0] d_shamt;
  shift_kind_e        d_sh;
  idx_mode_e          d_mode;
  logic               d_bad;
  logic [DW-1:0]      ofs;

  logic [DW-1:0] sum_n;
  logic [DW-1:0] addr_n;
  logic          wben_n;
  logic          ill_n;

  logic               valid_q;
  logic [DW-1:0]      addr_q;
  logic               wben_q;
  logic [REGIX_W-1:0] idx_q;
  logic [DW-1:0]      wbval_q;
  logic               load_q;
  logic               byte_q;
  logic               ill_q;
  logic               bend_q;

  ls_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  ls_field_decode u_dec (
    .instr    (instr),
    .reg_ofs  (d_reg_ofs),
    .up       (d_up),
    .byte_acc (d_byte),
    .load     (d_load),
    .rn       (d_rn),
    .imm      (d_imm),
    .shamt    (d_shamt),
    .sh       (d_sh),
    .mode     (d_mode),
    .bad      (d_bad)
  );

  ls_offset_gen #(.DW(DW)) u_ofs (
    .reg_ofs (d_reg_ofs),
    .imm     (d_imm),
    .shamt   (d_shamt),
    .sh      (d_sh),
    .ofs_val (ofs_val),
    .ofs     (ofs)
  );

  // next-state
  always_comb begin
    sum_n  = d_up ? (base_val + ofs) : (base_val - ofs);
    addr_n = ((d_mode == MODE_OFFSET) || (d_mode == MODE_PRE)) ? sum_n : base_val;
    wben_n = in_valid && !d_bad && ((d_mode == MODE_PRE) || (d_mode == MODE_POST));
    ill_n  = in_valid && d_bad;
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      valid_q <= 1'b0;
      wben_q  <= 1'b0;
      ill_q   <= 1'b0;
      addr_q  <= '0;
      idx_q   <= '0;
      wbval_q <= '0;
      load_q  <= 1'b0;
      byte_q  <= 1'b0;
      bend_q  <= 1'b0;
    end else begin
      valid_q <= in_valid;
      wben_q  <= wben_n;
      ill_q   <= ill_n;
      if (in_valid) begin
        addr_q  <= addr_n;
        idx_q   <= d_rn;
        wbval_q <= sum_n;
        load_q  <= d_load;
        byte_q  <= d_byte;
        bend_q  <= big_end;
      end
    end
  end

  ls_lane_pick #(.DW(DW)) u_lane (
    .word     (ld_word),
    .lane     (addr_q[LANE_W-1:0]),
    .big_end  (bend_q),
    .byte_acc (byte_q),
    .load     (load_q),
    .result   (ld_result)
  );

  assign out_valid = valid_q;
  assign mem_addr  = addr_q;
  assign wb_en     = wben_q;
  assign wb_idx    = idx_q;
  assign wb_val    = wbval_q;
  assign is_load   = load_q;
  assign is_byte   = byte_q;
  assign illegal   = ill_q;

endmodule

// File: rtl/ls_agu_checker.sv
module ls_agu_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_q_n,
  input logic          in_valid,
  input logic          out_valid,
  input logic          wb_en,
  input logic          illegal,
  input logic          is_load,
  input logic          is_byte,
  input logic [DW-1:0] mem_addr,
  input logic [DW-1:0] ld_result
);

  assert_wben_with_valid_R11: assert property (@(posedge clk) disable iff (!rst_q_n)
    wb_en |-> out_valid);

  assert_illegal_no_wb_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    illegal |-> (out_valid && !wb_en));

  assert_strobe_follows_R11: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> out_valid);

  assert_strobe_drops_R11: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> !out_valid);

  assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> $stable(mem_addr));

  assert_store_zero_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !is_load |-> (ld_result == '0));

  assert_byte_extend_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (is_load && is_byte) |-> (ld_result[DW-1:8] == '0));

endmodule

bind ls_agu ls_agu_checker #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .wb_en     (wb_en),
  .illegal   (illegal),
  .is_load   (is_load),
  .is_byte   (is_byte),
  .mem_addr  (mem_addr),
  .ld_result (ld_result)
);

// File: tb/tb_ls_agu.sv
`timescale 1ns/1ps
module tb_ls_agu;

  localparam int NV = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] instr;
  logic [31:0] base_val;
  logic [31:0] ofs_val;
  logic        big_end;
  logic [31:0] ld_word;
  logic        out_valid;
  logic [31:0] mem_addr;
  logic        wb_en;
  logic [3:0]  wb_idx;
  logic [31:0] wb_val;
  logic        is_load;
  logic        is_byte;
  logic        illegal;
  logic [31:0] ld_result;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ls_agu dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .base_val(base_val), .ofs_val(ofs_val), .big_end(big_end), .ld_word(ld_word),
    .out_valid(out_valid), .mem_addr(mem_addr), .wb_en(wb_en), .wb_idx(wb_idx),
    .wb_val(wb_val), .is_load(is_load), .is_byte(is_byte), .illegal(illegal),
    .ld_result(ld_result)
  );

  // instr, base, offset reg, load word, byte order, addr, wb_en, wb_val, ld_result, illegal
  localparam logic [31:0] V_INS [NV] = '{
    32'hE7943005, 32'hE5949010, 32'hE5221008, 32'hE6D45107,
    32'hE6D45107, 32'hE7510223, 32'hE79310C2, 32'hE7931466,
    32'hE4B21004, 32'hE0943005, 32'hE5D12003, 32'hE4443010};
  localparam logic [31:0] V_BASE [NV] = '{
    32'h100, 32'h1000, 32'h200, 32'h9, 32'h9, 32'h1000,
    32'h10000, 32'h10, 32'h40, 32'h80, 32'h100, 32'h500};
  localparam logic [31:0] V_OFS [NV] = '{
    32'h20, 32'h0, 32'h0, 32'h3, 32'h3, 32'h300,
    32'hFFFFFFF0, 32'hAB, 32'h0, 32'h0, 32'h0, 32'h0};
  localparam logic [31:0] V_WORD [NV] = '{
    32'hCAFEF00D, 32'h0BADBEEF, 32'hFFFFFFFF, 32'h23456789,
    32'h23456789, 32'hA1B2C3D4, 32'h11223344, 32'h55667788,
    32'h12345678, 32'h0, 32'h23456789, 32'hFFFFFFFF};
  localparam logic V_BE [NV] = '{0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 1, 0};
  localparam logic [31:0] V_ADDR [NV] = '{
    32'h120, 32'h1010, 32'h1F8, 32'h9, 32'h9, 32'hFD0,
    32'hFFF8, 32'hAB000010, 32'h40, 32'h80, 32'h103, 32'h500};
  localparam logic V_WBEN [NV] = '{0, 0, 1, 1, 1, 0, 0, 0, 0, 0, 0, 1};
  localparam logic [31:0] V_WBV [NV] = '{
    32'h120, 32'h1010, 32'h1F8, 32'h15, 32'h15, 32'hFD0,
    32'hFFF8, 32'hAB000010, 32'h44, 32'h85, 32'h103, 32'h4F0};
  localparam logic [31:0] V_LD [NV] = '{
    32'hCAFEF00D, 32'h0BADBEEF, 32'h0, 32'h67, 32'h45, 32'hD4,
    32'h11223344, 32'h55667788, 32'h12345678, 32'h0, 32'h89, 32'h0};
  localparam logic V_ILL [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0};
  localparam string V_REQ [NV] = '{
    "R3 R4 R5", "R2 R5", "R4 R6", "R7 R9", "R10", "R3 R5 R9",
    "R3 ASR", "R3 ROR", "R8", "R1", "R10 R2", "R7 R9"};

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input int k);
    @(negedge clk);
    in_valid = 1'b1;
    instr    = V_INS[k];
    base_val = V_BASE[k];
    ofs_val  = V_OFS[k];
    big_end  = V_BE[k];
    ld_word  = V_WORD[k];
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; instr = '0; base_val = '0;
    ofs_val = '0; big_end = 1'b0; ld_word = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R12 reset state
    chk("R12", "out_valid", {31'b0, out_valid}, 32'h0);
    chk("R12", "mem_addr", mem_addr, 32'h0);
    chk("R12", "wb_en", {31'b0, wb_en}, 32'h0);
    chk("R12", "wb_val", wb_val, 32'h0);
    chk("R12", "illegal", {31'b0, illegal}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // vector table: R1..R10
    for (int k = 0; k < NV; k++) begin
      drive(k);
      chk(V_REQ[k], "out_valid R11", {31'b0, out_valid}, 32'h1);
      chk(V_REQ[k], "mem_addr", mem_addr, V_ADDR[k]);
      chk(V_REQ[k], "wb_en", {31'b0, wb_en}, {31'b0, V_WBEN[k]});
      chk(V_REQ[k], "wb_val", wb_val, V_WBV[k]);
      chk(V_REQ[k], "wb_idx R6", {28'b0, wb_idx}, {28'b0, V_INS[k][19:16]});
      chk(V_REQ[k], "ld_result", ld_result, V_LD[k]);
      chk(V_REQ[k], "illegal", {31'b0, illegal}, {31'b0, V_ILL[k]});
    end

    // R11: strobe is one cycle, results hold while idle
    drive(2);
    base_val = 32'hDEAD0000;
    instr    = 32'hE5A00004;
    @(negedge clk);
    chk("R11", "out_valid idle", {31'b0, out_valid}, 32'h0);
    chk("R11", "wb_en idle", {31'b0, wb_en}, 32'h0);
    chk("R11", "mem_addr hold", mem_addr, 32'h1F8);
    chk("R11", "wb_val hold", wb_val, 32'h1F8);
    @(negedge clk);
    chk("R11", "mem_addr hold 2", mem_addr, 32'h1F8);

    // R12: reset mid-run clears at once
    drive(3);
    rst_n = 1'b0;
    #1;
    chk("R12", "out_valid async", {31'b0, out_valid}, 32'h0);
    chk("R12", "mem_addr async", mem_addr, 32'h0);
    chk("R12", "wb_en async", {31'b0, wb_en}, 32'h0);
    chk("R12", "wb_val async", wb_val, 32'h0);
    chk("R12", "is_load async", {31'b0, is_load}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    drive(1);
    chk("R12", "addr after release", mem_addr, 32'h1010);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule